// File: doc/BRIEF.md
# Split-Bus Packet Header and Payload Transmit Sequencer

This block sits between a packet-building client and a transmit port that takes packet headers and packet payload on two separate handshaked buses. The client hands over one command per packet: the header format, packet type, a 32-bit or 64-bit address, a length in 32-bit words, requester and tag fields, byte enables and a two-bit group tag. The block packs these into a 128-bit header word. It raises a request with that header word and holds both unchanged until the port acknowledges.

For packets that carry a payload, the block then pulls 32-bit words from a valid/ready stream and packs them into 64-bit beats. The lane of the first word follows address bit 2, so the beats line up with the 64-bit alignment of the target address. Each beat is qualified by a valid output and can be held off by a stall input. The final beat carries an end flag. Header-only packets finish on the acknowledge, and a following header-only command can be taken in that same cycle, so the request can stay high from one packet to the next.

Top module: `tlp_tx_sequencer`

## Requirements
- R1: After a synchronous active-low reset, cmd_ready is 1 and hdr_req, beat_valid and pl_ready are 0.
- R2: With cmd_fmt[0]=0 (3-word header), hdr_bus[127:96] = {cmd_group, cmd_fmt[0], cmd_type, 14 zero bits, cmd_len}, hdr_bus[95:64] = {cmd_req_id, cmd_tag, cmd_last_be, cmd_first_be}, hdr_bus[63:32] = {cmd_addr[31:2], 2'b00} and hdr_bus[31:0] = 0, so address bit 2 lands in hdr_bus bit 34.
- R3: With cmd_fmt[0]=1 (4-word header), the upper 64 bits are as in R2, hdr_bus[63:32] = cmd_addr[63:32] and hdr_bus[31:0] = {cmd_addr[31:2], 2'b00}, so address bit 2 lands in hdr_bus bit 2.
- R4: hdr_bus[127:126] always carries cmd_group.
- R5: hdr_req rises one cycle after a command is accepted. While hdr_ack is 0, hdr_req and hdr_bus stay unchanged.
- R6: A command with cmd_fmt[1]=0 (no payload) completes on the hdr_ack cycle with no payload beat. In that cycle cmd_ready is 1, and a command accepted then keeps hdr_req high on the next cycle with the new header.
- R7: For a command with cmd_fmt[1]=1, the first payload word goes on beat_bus[31:0] when cmd_addr[2]=0 and on beat_bus[63:32] when cmd_addr[2]=1. Later words fill the lanes in order.
- R8: The number of beats is ceil((N + cmd_addr[2]) / 2), where N is the word count. Exactly N payload words are consumed. beat_end is 1 on the last beat only, and no beat is shown while hdr_req is high.
- R9: Lanes of the first and last beats that hold no payload word are driven to zero.
- R10: While beat_valid and beat_stall are both 1, beat_bus, beat_end and beat_valid hold their values into the next cycle.
- R11: cmd_len = 0 means 1024 payload words (513 beats when cmd_addr[2]=1).
- R12: cmd_ready stays 0 from the acceptance of a payload-carrying command until its last beat is taken (beat_valid, beat_end and no beat_stall).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken this cycle when cmd_valid is 1 |
| cmd_fmt | input | 2 | Bit 1: payload present; bit 0: 4-word header (64-bit address) |
| cmd_type | input | 5 | Packet type field |
| cmd_addr | input | 64 | Target address (upper half ignored for 3-word headers) |
| cmd_len | input | 10 | Length in 32-bit words, 0 means 1024 |
| cmd_req_id | input | 16 | Requester identifier |
| cmd_tag | input | 8 | Transaction tag |
| cmd_first_be | input | 4 | First-word byte enables |
| cmd_last_be | input | 4 | Last-word byte enables |
| cmd_group | input | 2 | Group tag placed in header bits [127:126] |
| pl_valid | input | 1 | Payload word present |
| pl_ready | output | 1 | Payload word taken this cycle when pl_valid is 1 |
| pl_dw | input | 32 | Payload word |
| hdr_req | output | 1 | Header request |
| hdr_ack | input | 1 | Header acknowledge |
| hdr_bus | output | 128 | Packed header word |
| beat_valid | output | 1 | Payload beat present |
| beat_stall | input | 1 | Holds the current beat |
| beat_bus | output | 64 | Payload beat, two word lanes |
| beat_end | output | 1 | Last beat of the packet |

## Verification
The bench sweeps header size, address bit 2, lengths one to five and stall and gap patterns. It checks every lane of every beat against an arithmetic model. A design that ignored the address bit would put the first word in the wrong lane. One that counted beats from the length alone would drop or add a beat when the offset is 1. One that left stale data in unused lanes would show non-zero garbage. Separate runs cover back-to-back header-only commands, where a design that forced an idle cycle would drop hdr_req, and a zero length field, where a design that used the raw value would send nothing or a single word instead of 1024.

// File: rtl/tlp_tx_pkg.sv
// Shared widths and command record for the split-bus transmit sequencer.
// Assumes a two-lane (64-bit) payload beat of 32-bit words.
package tlp_tx_pkg;
    localparam int DW_W     = 32;
    localparam int BEAT_W   = 64;
    localparam int HDR_W    = 128;
    localparam int LEN_W    = 10;
    localparam int ADDR_W   = 64;
    localparam int LANES    = BEAT_W / DW_W;
    localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int CNT_W    = LEN_W + 1;
    localparam int PAD_W    = 24 - LEN_W;
    localparam int LANE_LSB = $clog2(DW_W / 8);

    typedef struct packed {
        logic [1:0]        group;
        logic              has_data;
        logic              wide_hdr;
        logic [4:0]        ptype;
        logic [LEN_W-1:0]  len;
        logic [15:0]       req_id;
        logic [7:0]        tag;
        logic [3:0]        last_be;
        logic [3:0]        first_be;
        logic [ADDR_W-1:0] addr;
    } tlp_cmd_t;

    // Word count from the length field; an all-zero field means the maximum.
    function automatic logic [CNT_W-1:0] word_count(input logic [LEN_W-1:0] l);
        return (l == '0) ? CNT_W'(1) << LEN_W : {1'b0, l};
    endfunction
endpackage

// File: rtl/tlp_hdr_pack.sv
// Packs a command record into the 128-bit header word.
// Assumes: byte 0 in the top bits, bits [127:126] carry the group tag,
// 3-word headers leave the bottom word at zero.
module tlp_hdr_pack
    import tlp_tx_pkg::*;
(
    input  tlp_cmd_t         cmd,
    output logic [HDR_W-1:0] hdr
);
    logic [DW_W-1:0] word0;
    logic [DW_W-1:0] word1;
    logic [DW_W-1:0] addr_lo;

    // Build the fixed words and select the tail by header size.
    always_comb begin
        word0   = {cmd.group, cmd.wide_hdr, cmd.ptype, {PAD_W{1'b0}}, cmd.len};
        word1   = {cmd.req_id, cmd.tag, cmd.last_be, cmd.first_be};
        addr_lo = {cmd.addr[31:2], 2'b00};
        if (cmd.wide_hdr)
            hdr = {word0, word1, cmd.addr[63:32], addr_lo};
        else
            hdr = {word0, word1, addr_lo, {DW_W{1'b0}}};
    end
endmodule

// File: rtl/tlp_beat_builder.sv
// Gathers payload words into lane-aligned beats and presents them with
// valid/stall. Assumes start arrives only when idle; the first word goes to
// start_lane, unused lanes stay zero, the last beat carries beat_end.
module tlp_beat_builder
    import tlp_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LANE_W-1:0] start_lane,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic              pl_valid,
    output logic              pl_ready,
    input  logic [DW_W-1:0]   pl_dw,
    output logic              beat_valid,
    input  logic              beat_stall,
    output logic [BEAT_W-1:0] beat_bus,
    output logic              beat_end,
    output logic              done
);
    typedef enum logic [1:0] {B_IDLE, B_FILL, B_SEND} bstate_t;

    bstate_t                     st_q;
    logic [LANE_W-1:0]           lane_q;
    logic [CNT_W-1:0]            left_q;
    logic                        last_q;
    logic [LANES-1:0][DW_W-1:0]  lanes_q;
    logic                        fill_fire;
    logic                        send_fire;
    logic                        beat_full;
    logic                        final_word;

    assign pl_ready   = (st_q == B_FILL);
    assign beat_valid = (st_q == B_SEND);
    assign fill_fire  = pl_ready && pl_valid;
    assign send_fire  = beat_valid && !beat_stall;
    assign final_word = (left_q == CNT_W'(1));
    assign beat_full  = (lane_q == LANE_W'(LANES - 1));
    assign done       = send_fire && last_q;
    assign beat_bus   = lanes_q;
    assign beat_end   = last_q;

    // Sequence fill and send phases and track words left and current lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= B_IDLE;
            lane_q <= '0;
            left_q <= '0;
            last_q <= 1'b0;
        end else begin
            case (st_q)
                B_IDLE: if (start) begin
                    st_q   <= B_FILL;
                    lane_q <= start_lane;
                    left_q <= start_cnt;
                    last_q <= 1'b0;
                end
                B_FILL: if (fill_fire) begin
                    left_q <= left_q - CNT_W'(1);
                    if (beat_full || final_word) begin
                        st_q   <= B_SEND;
                        last_q <= final_word;
                    end else begin
                        lane_q <= lane_q + LANE_W'(1);
                    end
                end
                B_SEND: if (send_fire) begin
                    st_q   <= last_q ? B_IDLE : B_FILL;
                    lane_q <= '0;
                end
                default: st_q <= B_IDLE;
            endcase
        end
    end

    // One register per lane: cleared at packet start and after each beat, loaded when addressed.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                lanes_q[g] <= '0;
            else if ((st_q == B_IDLE && start) || (send_fire && !last_q))
                lanes_q[g] <= '0;
            else if (fill_fire && lane_q == LANE_W'(g))
                lanes_q[g] <= pl_dw;
        end
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_stall |=> beat_valid && $stable(beat_bus) && $stable(beat_end));

    // R8
    end_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_end && !beat_stall |=> !beat_valid && !pl_ready);
endmodule

// File: rtl/tlp_tx_sequencer.sv
// Top level: takes one command, presents its header with request/acknowledge,
// then streams payload beats for packets that carry data. Assumes packets are
// well formed; a new command is taken only once the previous one is finished.
module tlp_tx_sequencer
    import tlp_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_fmt,
    input  logic [4:0]        cmd_type,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [15:0]       cmd_req_id,
    input  logic [7:0]        cmd_tag,
    input  logic [3:0]        cmd_first_be,
    input  logic [3:0]        cmd_last_be,
    input  logic [1:0]        cmd_group,
    input  logic              pl_valid,
    output logic              pl_ready,
    input  logic [DW_W-1:0]   pl_dw,
    output logic              hdr_req,
    input  logic              hdr_ack,
    output logic [HDR_W-1:0]  hdr_bus,
    output logic              beat_valid,
    input  logic              beat_stall,
    output logic [BEAT_W-1:0] beat_bus,
    output logic              beat_end
);
    typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA} sstate_t;

    sstate_t  st_q;
    tlp_cmd_t cur_q;
    tlp_cmd_t incoming;
    logic     accept;
    logic     data_start;
    logic     data_done;

    // Gather the command inputs into one record.
    always_comb begin
        incoming          = '0;
        incoming.group    = cmd_group;
        incoming.has_data = cmd_fmt[1];
        incoming.wide_hdr = cmd_fmt[0];
        incoming.ptype    = cmd_type;
        incoming.len      = cmd_len;
        incoming.req_id   = cmd_req_id;
        incoming.tag      = cmd_tag;
        incoming.last_be  = cmd_last_be;
        incoming.first_be = cmd_first_be;
        incoming.addr     = cmd_addr;
    end

    // Ready when idle, at a header-only acknowledge, or as the last beat leaves.
    always_comb begin
        cmd_ready = (st_q == S_IDLE)
                 || (st_q == S_HDR && hdr_ack && !cur_q.has_data)
                 || (st_q == S_DATA && data_done);
    end

    assign accept     = cmd_valid && cmd_ready;
    assign hdr_req    = (st_q == S_HDR);
    assign data_start = hdr_req && hdr_ack && cur_q.has_data;

    // Packet-level sequencing and command capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cur_q <= '0;
        end else if (accept) begin
            st_q  <= S_HDR;
            cur_q <= incoming;
        end else begin
            case (st_q)
                S_HDR:   if (hdr_ack) st_q <= cur_q.has_data ? S_DATA : S_IDLE;
                S_DATA:  if (data_done) st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    tlp_hdr_pack u_pack (
        .cmd (cur_q),
        .hdr (hdr_bus)
    );

    tlp_beat_builder u_beats (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (data_start),
        .start_lane (cur_q.addr[LANE_LSB +: LANE_W]),
        .start_cnt  (word_count(cur_q.len)),
        .pl_valid   (pl_valid),
        .pl_ready   (pl_ready),
        .pl_dw      (pl_dw),
        .beat_valid (beat_valid),
        .beat_stall (beat_stall),
        .beat_bus   (beat_bus),
        .beat_end   (beat_end),
        .done       (data_done)
    );

    // R5
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_req && !hdr_ack |=> hdr_req && $stable(hdr_bus));

    // R12
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_end |-> !cmd_ready);

    // R8
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_req && beat_valid));

    // R5
    req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> hdr_req);
endmodule

// File: tb/tlp_tx_sequencer_bench.sv
module tlp_tx_sequencer_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [1:0]   cmd_fmt = '0;
    logic [4:0]   cmd_type = '0;
    logic [63:0]  cmd_addr = '0;
    logic [9:0]   cmd_len = '0;
    logic [15:0]  cmd_req_id = '0;
    logic [7:0]   cmd_tag = '0;
    logic [3:0]   cmd_first_be = '0;
    logic [3:0]   cmd_last_be = '0;
    logic [1:0]   cmd_group = '0;
    logic         pl_valid;
    logic         pl_ready;
    logic [31:0]  pl_dw;
    logic         hdr_req;
    logic         hdr_ack = 1'b0;
    logic [127:0] hdr_bus;
    logic         beat_valid;
    logic         beat_stall;
    logic [63:0]  beat_bus;
    logic         beat_end;

    int checks = 0;
    int errors = 0;
    bit gap_mode = 0;
    bit wait_mode = 0;
    bit mon_active = 0;
    bit pkt_done = 0;
    int exp_len = 0;
    int exp_off = 0;
    int nbeats = 0;
    int beat_k = 0;
    logic [31:0] exp_base = '0;

    always #4 clk = ~clk;

    tlp_tx_sequencer u_tlp_tx_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_fmt(cmd_fmt), .cmd_type(cmd_type), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .cmd_req_id(cmd_req_id), .cmd_tag(cmd_tag), .cmd_first_be(cmd_first_be),
        .cmd_last_be(cmd_last_be), .cmd_group(cmd_group), .pl_valid(pl_valid),
        .pl_ready(pl_ready), .pl_dw(pl_dw), .hdr_req(hdr_req), .hdr_ack(hdr_ack),
        .hdr_bus(hdr_bus), .beat_valid(beat_valid), .beat_stall(beat_stall),
        .beat_bus(beat_bus), .beat_end(beat_end)
    );

    task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [127:0] model_hdr(input logic [1:0] fmt, input logic [4:0] ty,
            input logic [9:0] ln, input logic [15:0] rid, input logic [7:0] tg,
            input logic [3:0] lbe, input logic [3:0] fbe, input logic [1:0] grp,
            input logic [63:0] ad);
        logic [31:0] w0, w1, alo;
        w0  = {grp, fmt[0], ty, 14'b0, ln};
        w1  = {rid, tg, lbe, fbe};
        alo = {ad[31:2], 2'b00};
        return fmt[0] ? {w0, w1, ad[63:32], alo} : {w0, w1, alo, 32'h0};
    endfunction

    // Payload source: incrementing words, optional gaps.
    initial begin
        bit fire;
        int ph;
        ph = 0;
        pl_dw = 32'h1000_0000;
        pl_valid = 1'b0;
        forever begin
            @(posedge clk);
            fire = pl_valid && pl_ready;
            @(negedge clk);
            if (fire) pl_dw = pl_dw + 1;
            ph++;
            pl_valid = !gap_mode || (ph % 3 != 0);
        end
    end

    // Beat monitor: arithmetic model of lanes, end flag and stalls.
    initial begin
        bit prev_stall;
        prev_stall = 0;
        beat_stall = 1'b0;
        forever begin
            @(negedge clk);
            if (beat_valid) begin
                if (!mon_active) chk(0, "R8 unexpected beat", {127'h0, beat_valid}, 128'h0);
                else begin
                    for (int l = 0; l < 2; l++) begin
                        int idx;
                        logic [31:0] ev;
                        string rq;
                        idx = 2 * beat_k + l - exp_off;
                        ev  = (idx >= 0 && idx < exp_len) ? exp_base + 32'(idx) : 32'h0;
                        rq  = (idx < 0 || idx >= exp_len) ? "R9 unused lane" :
                              prev_stall ? "R10 held beat" : (beat_k == 0) ? "R7 first lane" : "R8 lane";
                        chk(beat_bus[32*l +: 32] == ev, rq, {96'h0, beat_bus[32*l +: 32]}, {96'h0, ev});
                    end
                    chk(beat_end == (beat_k == nbeats - 1), "R8 end flag",
                        {127'h0, beat_end}, {127'h0, 1'b1 & (beat_k == nbeats - 1)});
                end
                beat_stall = wait_mode && !prev_stall;
                prev_stall = beat_stall;
                #1;
                if (!beat_end && cmd_ready) chk(0, "R12 ready mid-payload", 128'h1, 128'h0);
                if (!beat_stall) begin
                    if (beat_end) pkt_done = 1;
                    beat_k++;
                end
            end else begin
                beat_stall = 1'b0;
                prev_stall = 0;
            end
        end
    end

    task automatic drive_cmd(input logic [1:0] fmt, input logic [9:0] ln,
                             input logic [1:0] grp, input logic [63:0] ad);
        cmd_fmt = fmt; cmd_len = ln; cmd_group = grp; cmd_addr = ad;
        cmd_type = {ln[2:0], 2'b01}; cmd_req_id = 16'hBEEF ^ {6'h0, ln};
        cmd_tag = ln[7:0] * 8'd3; cmd_first_be = 4'hF; cmd_last_be = ln[3:0];
    endtask

    task automatic run_pkt(input bit w64, input bit hasd, input bit a2, input logic [9:0] ln,
                           input logic [1:0] grp, input bit wm, input bit gm);
        logic [63:0]  ad;
        logic [127:0] eh;
        int guard;
        ad = w64 ? {32'h1234_5600 | 32'(ln), 32'h8000_0000 | (32'(ln) << 4) | (32'(a2) << 2)}
                 : {32'h0, 32'h4000_0000 | (32'(ln) << 4) | (32'(a2) << 2)};
        wait_mode = wm; gap_mode = gm;
        exp_off  = a2;
        exp_len  = (ln == 0) ? 1024 : int'(ln);
        nbeats   = (exp_len + exp_off + 1) / 2;
        exp_base = pl_dw;
        beat_k   = 0; pkt_done = 0; mon_active = hasd;
        drive_cmd({hasd, w64}, ln, grp, ad);
        eh = model_hdr({hasd, w64}, cmd_type, ln, cmd_req_id, cmd_tag, cmd_last_be, cmd_first_be, grp, ad);
        cmd_valid = 1'b1;
        guard = 0;
        #1;
        while (!cmd_ready && guard < 50) begin @(negedge clk); #1; guard++; end
        @(negedge clk); cmd_valid = 1'b0; #1;
        chk(hdr_req == 1'b1, "R5 request raised", {127'h0, hdr_req}, 128'h1);
        chk(hdr_bus == eh, w64 ? "R3 wide header" : "R2 short header", hdr_bus, eh);
        chk(hdr_bus[127:126] == grp, "R4 group tag", {126'h0, hdr_bus[127:126]}, {126'h0, grp});
        repeat (2) begin
            @(negedge clk); #1;
            chk(hdr_req && hdr_bus == eh, "R5 header held", hdr_bus, eh);
        end
        @(negedge clk); hdr_ack = 1'b1; #1;
        if (!hasd) chk(cmd_ready == 1'b1, "R6 ready at ack", {127'h0, cmd_ready}, 128'h1);
        else chk(cmd_ready == 1'b0, "R12 busy at ack", {127'h0, cmd_ready}, 128'h0);
        @(negedge clk); hdr_ack = 1'b0; #1;
        if (!hasd) begin
            chk(!hdr_req && !beat_valid, "R6 header-only done", {126'h0, hdr_req, beat_valid}, 128'h0);
        end else begin
            guard = 0;
            while (!pkt_done && guard < 5000) begin
                if (!beat_valid && cmd_ready) chk(0, "R12 ready during fill", 128'h1, 128'h0);
                @(negedge clk); #1; guard++;
            end
            chk(beat_k == nbeats, (ln == 0) ? "R11 beat count" : "R8 beat count", 128'(beat_k), 128'(nbeats));
            chk(pl_dw - exp_base == 32'(exp_len), (ln == 0) ? "R11 words used" : "R8 words used",
                128'(pl_dw - exp_base), 128'(exp_len));
        end
        mon_active = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] ea, eb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(cmd_ready && !hdr_req && !beat_valid && !pl_ready, "R1 reset state",
            {124'h0, cmd_ready, hdr_req, beat_valid, pl_ready}, 128'h8);

        for (int w = 0; w < 2; w++)
            for (int a = 0; a < 2; a++)
                for (int ln = 1; ln <= 5; ln++)
                    for (int wm = 0; wm < 2; wm++)
                        run_pkt(w[0], 1'b1, a[0], 10'(ln), 2'(ln), wm[0], ln[0]);

        for (int g = 0; g < 4; g++)
            run_pkt(g[0], 1'b0, g[1], 10'(g + 2), 2'(g), 1'b0, 1'b0);

        // R6 back-to-back header-only commands.
        @(negedge clk);
        drive_cmd(2'b00, 10'd4, 2'd1, 64'h0000_0000_2000_0010);
        ea = model_hdr(2'b00, cmd_type, 10'd4, cmd_req_id, cmd_tag, cmd_last_be, cmd_first_be, 2'd1, cmd_addr);
        cmd_valid = 1'b1;
        @(negedge clk); #1;
        chk(hdr_req && hdr_bus == ea, "R6 first header", hdr_bus, ea);
        hdr_ack = 1'b1;
        drive_cmd(2'b01, 10'd7, 2'd2, 64'hAB00_0001_2000_0024);
        eb = model_hdr(2'b01, cmd_type, 10'd7, cmd_req_id, cmd_tag, cmd_last_be, cmd_first_be, 2'd2, cmd_addr);
        #1;
        chk(cmd_ready == 1'b1, "R6 ready for next", {127'h0, cmd_ready}, 128'h1);
        @(negedge clk); hdr_ack = 1'b0; cmd_valid = 1'b0; #1;
        chk(hdr_req && hdr_bus == eb, "R6 continuous request", hdr_bus, eb);
        hdr_ack = 1'b1;
        @(negedge clk); hdr_ack = 1'b0; #1;
        chk(!hdr_req, "R6 request dropped", {127'h0, hdr_req}, 128'h0);

        run_pkt(1'b1, 1'b1, 1'b1, 10'd0, 2'd3, 1'b1, 1'b0);
        run_pkt(1'b0, 1'b1, 1'b0, 10'd0, 2'd0, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule